// File: doc/BRIEF.md
# Fan Drive Saturation Fault Detector

This block supervises one closed-loop fan channel. It decides when a fan that is already driven at full output still turns too slowly to reach the speed the loop is asking for. The block samples a measured tach count, the target tach count and a tolerance band each time a new measurement arrives. It then checks whether the fan falls short by more than the band.

A shortfall only counts while the speed loop is running and the upper byte of the drive setting is pinned at FFh. It must repeat on a selectable number of back-to-back measurements before the block latches a sticky fault flag. The fault flag drives an interrupt line through an enable, and software clears it with a one-cycle clear pulse.

Tach counts grow as the fan slows down. A measurement therefore fails when the measured count is larger than the target count plus the band.

Top module: `drive_fail_detect`

## Requirements
- R1: While reset is asserted and after it is released, `fail_sts` and `irq` are 0 until a fault is detected.
- R2: The 13-bit band is built from two bytes. Band bits 12..5 come from `band_hi[7:0]`, and band bits 4..0 come from `band_lo[7:3]`. `band_lo[2:0]` has no effect.
- R3: A measurement fails when `meas_cnt > tgt_cnt + band`. The sum is formed in 14 bits, so large target and band values never wrap into a false failure.
- R4: A strobe taken while `drive_hi` is not FFh counts as non-failing and restarts the persistence count at zero.
- R5: On every clock where `loop_on` is 0, the persistence count is held at zero, whether or not a strobe is present.
- R6: `persist_sel` selects the run length: 01 means 16, 10 means 32, 11 means 64 consecutive failing strobes. 00 disables detection, so the status is never set.
- R7: `fail_sts` goes high in the cycle after the strobe that completes the selected run of consecutive failing strobes, and not earlier.
- R8: A strobe whose measurement does not fail restarts the persistence count at zero.
- R9: `fail_sts` is sticky and falls only in the cycle after `clr` is high. If a completing failing strobe and `clr` occur in the same cycle, the status stays set.
- R10: `irq` equals `fail_sts` ANDed with `irq_en`.
- R11: Cycles without `upd` leave the persistence count unchanged. Failing strobes separated by idle cycles still count as consecutive.
- R12: The count saturates at the run length. After a clear, a single further failing strobe sets the status again if the run was never broken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| upd | input | 1 | One-cycle strobe marking a new tach measurement |
| meas_cnt | input | 13 | Measured tach count |
| tgt_cnt | input | 13 | Target tach count |
| band_lo | input | 8 | Band low byte (bits 7..3 hold band bits 4..0) |
| band_hi | input | 8 | Band high byte (band bits 12..5) |
| drive_hi | input | 8 | Upper byte of the current drive setting |
| loop_on | input | 1 | Speed-control loop active |
| persist_sel | input | 2 | Persistence run-length select |
| irq_en | input | 1 | Interrupt enable |
| clr | input | 1 | Status clear pulse |
| fail_sts | output | 1 | Sticky drive-fail status |
| irq | output | 1 | Interrupt request |

## Verification
Two functions can fall in the same clock: the clear pulse and the failing strobe that completes a run. They can meet either on the first completion or after saturation, when one extra failing strobe re-arms the fault. The bench provokes both cases by raising `clr` together with that strobe. A behavioural model expects the status to survive, and the next cycle confirms that a lone clear does drop it.

// File: rtl/drive_fail_detect.sv
module drive_fail_detect (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        upd,
  input  logic [12:0] meas_cnt,
  input  logic [12:0] tgt_cnt,
  input  logic [7:0]  band_lo,
  input  logic [7:0]  band_hi,
  input  logic [7:0]  drive_hi,
  input  logic        loop_on,
  input  logic [1:0]  persist_sel,
  input  logic        irq_en,
  input  logic        clr,
  output logic        fail_sts,
  output logic        irq
);
  localparam int TW = 13;
  localparam int CW = 7;

  logic [TW-1:0] band;
  logic [TW:0]   limit;
  logic [CW-1:0] thr;
  logic [CW-1:0] cnt;
  logic          short_fall, armed, hit, reach;

  assign band       = {band_hi, band_lo[7:3]};
  assign limit      = {1'b0, tgt_cnt} + {1'b0, band};
  assign short_fall = {1'b0, meas_cnt} > limit;
  assign armed      = loop_on && (drive_hi == 8'hFF) && (persist_sel != 2'b00);
  assign hit        = upd && armed && short_fall;
  assign reach      = hit && (cnt >= thr - 7'd1);

  always_comb begin
    case (persist_sel)
      2'b01:   thr = 7'd16;
      2'b10:   thr = 7'd32;
      2'b11:   thr = 7'd64;
      default: thr = 7'd0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      cnt <= '0;
    else if (!loop_on)
      cnt <= '0;
    else if (upd) begin
      if (!hit)
        cnt <= '0;
      else if (cnt >= thr)
        cnt <= thr;
      else
        cnt <= cnt + 7'd1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      fail_sts <= 1'b0;
    else if (reach)
      fail_sts <= 1'b1;
    else if (clr)
      fail_sts <= 1'b0;
  end

  assign irq = fail_sts & irq_en;
endmodule

// File: rtl/drive_fail_detect_chk.sv
module drive_fail_detect_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       upd,
  input logic [7:0] drive_hi,
  input logic       loop_on,
  input logic [1:0] persist_sel,
  input logic       irq_en,
  input logic       clr,
  input logic       fail_sts,
  input logic       irq
);
  a_r9_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    fail_sts && !clr |=> fail_sts);
  a_r9_clear: assert property (@(posedge clk) disable iff (!rst_n)
    clr && !upd |=> !fail_sts);
  a_r7_needs_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    !fail_sts && !upd |=> !fail_sts);
  a_r5_loop_off: assert property (@(posedge clk) disable iff (!rst_n)
    !fail_sts && !loop_on |=> !fail_sts);
  a_r6_sel_off: assert property (@(posedge clk) disable iff (!rst_n)
    !fail_sts && persist_sel == 2'b00 |=> !fail_sts);
  a_r4_low_drive: assert property (@(posedge clk) disable iff (!rst_n)
    !fail_sts && drive_hi != 8'hFF |=> !fail_sts);
  a_r10_irq_masked: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_en |-> !irq);
endmodule

bind drive_fail_detect drive_fail_detect_chk u_chk (
  .clk(clk), .rst_n(rst_n), .upd(upd), .drive_hi(drive_hi),
  .loop_on(loop_on), .persist_sel(persist_sel), .irq_en(irq_en),
  .clr(clr), .fail_sts(fail_sts), .irq(irq)
);

// File: tb/drive_fail_detect_tb.sv
module drive_fail_detect_tb;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic upd = 0, loop_on = 0, irq_en = 0, clr = 0;
  logic [12:0] meas_cnt = 0, tgt_cnt = 0;
  logic [7:0]  band_lo = 0, band_hi = 0, drive_hi = 0;
  logic [1:0]  persist_sel = 0;
  logic fail_sts, irq;

  int total = 0, bad = 0;
  int mcnt = 0;
  bit msts = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  drive_fail_detect u_dut (
    .clk(clk), .rst_n(rst_n), .upd(upd), .meas_cnt(meas_cnt),
    .tgt_cnt(tgt_cnt), .band_lo(band_lo), .band_hi(band_hi),
    .drive_hi(drive_hi), .loop_on(loop_on), .persist_sel(persist_sel),
    .irq_en(irq_en), .clr(clr), .fail_sts(fail_sts), .irq(irq)
  );

  task automatic check(string tag, logic act, logic exp, string what);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%0b expected=%0b t=%0t", tag, what, act, exp, $time);
    end
  endtask

  // model one clock edge with the inputs as driven now, then compare
  task automatic tick(string tag);
    int band, thr;
    bit fail, setnow;
    band = int'(band_hi) * 32 + int'(band_lo) / 8;
    fail = int'(meas_cnt) > int'(tgt_cnt) + band;
    thr  = (persist_sel == 1) ? 16 : (persist_sel == 2) ? 32 : 64;
    setnow = 0;
    if (!loop_on) mcnt = 0;
    else if (upd) begin
      if (persist_sel != 0 && drive_hi == 8'hFF && fail) begin
        setnow = (mcnt >= thr - 1);
        mcnt = (mcnt >= thr) ? thr : mcnt + 1;
      end else mcnt = 0;
    end
    if (setnow) msts = 1;
    else if (clr) msts = 0;
    @(posedge clk);
    @(negedge clk);
    check(tag, fail_sts, msts, "fail_sts");
    check("R10", irq, msts & irq_en, "irq");
  endtask

  task automatic strobes(int n, string tag, int gap);
    for (int i = 0; i < n; i++) begin
      upd = 1; tick(tag); upd = 0;
      for (int g = 0; g < gap; g++) tick("R11");
    end
  endtask

  task automatic pulse_clr(string tag);
    clr = 1; tick(tag); clr = 0;
  endtask

  initial begin
    fork
      begin
        repeat (3) @(negedge clk);
        check("R1", fail_sts, 1'b0, "fail_sts in reset");
        check("R1", irq, 1'b0, "irq in reset");
        rst_n = 1;
        tick("R1");
        loop_on = 1; drive_hi = 8'hFF; persist_sel = 2'b01; irq_en = 1;
        tgt_cnt = 13'd1000; band_hi = 8'd2; band_lo = 8'b0001_1111; // band 67
        meas_cnt = 13'd1067; strobes(20, "R2", 0);   // equal: no fail, lo[2:0] ignored
        meas_cnt = 13'd1068; strobes(15, "R7", 2);   // one short of 16, with idle gaps
        strobes(1, "R7", 0);                         // 16th sets
        pulse_clr("R9");
        strobes(1, "R12", 0);                        // saturated: one strobe re-sets
        pulse_clr("R9");
        meas_cnt = 13'd1000; strobes(1, "R8", 0);
        meas_cnt = 13'd1068; strobes(15, "R8", 0);
        meas_cnt = 13'd1000; strobes(1, "R8", 0);
        meas_cnt = 13'd1068; strobes(10, "R4", 0);
        drive_hi = 8'hFE; strobes(3, "R4", 0);
        drive_hi = 8'hFF; strobes(15, "R4", 0);
        loop_on = 0; tick("R5"); loop_on = 1;
        strobes(15, "R5", 0);
        strobes(1, "R7", 0);
        irq_en = 0; tick("R10"); irq_en = 1; tick("R10");
        clr = 1; strobes(1, "R9", 0); clr = 0;       // set wins over clear
        pulse_clr("R9");
        persist_sel = 2'b00; strobes(100, "R6", 0);
        persist_sel = 2'b10; strobes(31, "R6", 0); strobes(1, "R6", 0);
        pulse_clr("R9");
        persist_sel = 2'b11; loop_on = 0; tick("R5"); loop_on = 1;
        strobes(63, "R6", 0);
        clr = 1; strobes(1, "R9", 0); clr = 0;
        pulse_clr("R9");
        tgt_cnt = 13'd8191; band_hi = 8'hFF; band_lo = 8'hFF; meas_cnt = 13'd8191;
        strobes(70, "R3", 0);
        tgt_cnt = 13'd100; band_hi = 8'd0; band_lo = 8'b0000_0111; meas_cnt = 13'd101;
        persist_sel = 2'b01; strobes(16, "R3", 0);
        check("R3", fail_sts, 1'b1, "set with band zero");
      end
      begin
        repeat (20000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog expired");
      end
    join_any
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule